// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block merges three groups of interrupt sources into a single interrupt line toward a processor. The groups are a display group, a graphics-engine group and a power-management group. Each group owns a sticky status register and an enable register. A one-cycle source pulse sets a status bit. Software acknowledges a bit by writing a one to it. A separate master enable gates the engine and power groups only. The display group reaches the output whatever the master enable holds.

The output is not a level. The block registers a combined condition and emits a single one-cycle pulse only when that registered condition rises from 0 to 1. If the condition stays high, no further pulse follows. So if a handler returns while bits are still pending, it must first bring the condition to zero. It does that by zeroing the master enable and the display enable together. Restoring them, in either order, then produces a fresh pulse while any enabled status bit remains set.

Registers are reached through a plain single-cycle write port and a combinational read port. A read of a status register returns the raw latched bits, not masked by the enable.

Top module: `irq_edge_combiner`

## Requirements
- R1: After reset, every register reads zero and cpu_irq stays low while no source is asserted.
- R2: A one-cycle source pulse sets the matching status bit, and the bit stays set over later cycles. When a source sets a bit in the same cycle as a write-one clears it, the bit ends up set.
- R3: Writing a word to a status address clears each bit where the word has a one and leaves the other bits unchanged.
- R4: The register map is as follows. Address 0 holds the display status and address 1 the display enable. Address 2 holds the engine status and address 3 the engine enable. Address 4 holds the power status and address 5 the power enable. Address 6 is the master control, whose only stored bit is bit 31 (the master enable); all its other bits read zero. Address 7 reads zero and ignores writes. Status reads are not masked by the enables, and enable registers read back the last word written.
- R5: The combined condition is true when any display status bit is set with its enable bit set. It is also true when the master enable is set and any engine or power status bit is set with its enable bit set.
- R6: Display interrupts raise the output while the master enable is zero.
- R7: cpu_irq is high for exactly one cycle. An input change at clock edge k that makes the condition true shows up as a status or enable change at edge k. That change puts cpu_irq high during the cycle after edge k+2.
- R8: While the combined condition stays true, no further pulse is produced. New enabled sources that arrive in that time add no pulse.
- R9: While enabled status bits remain set, software can zero the master enable and the display enable together and then restore them, in either order. This produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_src | input | WIDTH | Display source pulses, one per status bit |
| eng_src | input | WIDTH | Graphics-engine source pulses |
| pwr_src | input | WIDTH | Power-management source pulses |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Combinational read data at reg_addr |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the processor |

## Verification
The assertions assume three things about the inputs. Source pulses and register writes are synchronous to clk. A write strobe lasts one cycle with its address and data stable. Nothing is driven before the internal reset has been released. The bench changes every input at the falling edge only, and holds sources and the write strobe low through reset and for several cycles after it. It drives each write and each source pulse for exactly one cycle, except the deliberate same-cycle set-and-clear case. It then waits long enough that the internal reset release has finished before any stimulus.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned NUM_GROUPS = 3;

  typedef enum logic [1:0] {
    GRP_DISP = 2'd0,
    GRP_ENG  = 2'd1,
    GRP_PWR  = 2'd2
  } grp_e;

  localparam logic [ADDR_W-1:0] ADDR_MASTER = 3'd6;

  // status at even address, enable at the odd address after it
  function automatic logic [ADDR_W-1:0] stat_addr(input int unsigned g);
    return ADDR_W'(2 * g);
  endfunction

  function automatic logic [ADDR_W-1:0] en_addr(input int unsigned g);
    return ADDR_W'(2 * g + 1);
  endfunction

endpackage

// File: rtl/irqagg_rst_sync.sv
module irqagg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/irqagg_group.sv
module irqagg_group
  import irqagg_pkg::*;
#(
  parameter int unsigned       WIDTH     = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  src,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  stat_o,
  output logic [WIDTH-1:0]  en_o,
  output logic              pend_o
);

  logic [WIDTH-1:0] stat_q, stat_d;
  logic [WIDTH-1:0] en_q, en_d;
  logic [WIDTH-1:0] clr_mask;
  logic             hit_stat, hit_en;
  logic             stat_ce, en_ce;

  always_comb begin
    hit_stat = wr_en && (wr_addr == STAT_ADDR);
    hit_en   = wr_en && (wr_addr == EN_ADDR);
    clr_mask = hit_stat ? wr_data : '0;
    // a source set in the same cycle wins over the clear
    stat_d   = (stat_q & ~clr_mask) | src;
    stat_ce  = hit_stat || (|src);
    en_d     = wr_data;
    en_ce    = hit_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

endmodule

// File: rtl/irqagg_master.sv
module irqagg_master
  import irqagg_pkg::*;
#(
  parameter int unsigned       WIDTH = 32,
  parameter logic [ADDR_W-1:0] ADDR  = ADDR_MASTER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic              master_o
);

  localparam int unsigned EN_BIT = WIDTH - 1;

  logic master_q, master_d, master_ce;

  always_comb begin
    master_ce = wr_en && (wr_addr == ADDR);
    master_d  = wr_data[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
    end else if (master_ce) begin
      master_q <= master_d;
    end
  end

  assign master_o = master_q;

endmodule

// File: rtl/irqagg_edge.sv
module irqagg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic cond_q_o,
  output logic irq_o
);

  logic cond_q, cond_qq, irq_q;
  logic irq_d;

  always_comb begin
    irq_d = cond_q & ~cond_qq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= 1'b0;
      cond_qq <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cond_q  <= cond_i;
      cond_qq <= cond_q;
      irq_q   <= irq_d;
    end
  end

  assign cond_q_o = cond_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/irq_edge_combiner.sv
module irq_edge_combiner
  import irqagg_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  disp_src,
  input  logic [WIDTH-1:0]  eng_src,
  input  logic [WIDTH-1:0]  pwr_src,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  output logic              cpu_irq
);

  localparam int unsigned IDX_DISP = int'(GRP_DISP);
  localparam int unsigned IDX_ENG  = int'(GRP_ENG);
  localparam int unsigned IDX_PWR  = int'(GRP_PWR);

  logic                  rst_n_sync;
  logic [WIDTH-1:0]      src_arr  [NUM_GROUPS];
  logic [WIDTH-1:0]      stat_arr [NUM_GROUPS];
  logic [WIDTH-1:0]      en_arr   [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend_vec;
  logic                  master_en;
  logic                  cond_comb;
  logic                  cond_q;
  logic [WIDTH-1:0]      disp_stat;
  logic [WIDTH-1:0]      disp_en;

  irqagg_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  always_comb begin
    src_arr[IDX_DISP] = disp_src;
    src_arr[IDX_ENG]  = eng_src;
    src_arr[IDX_PWR]  = pwr_src;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqagg_group #(
      .WIDTH     (WIDTH),
      .STAT_ADDR (stat_addr(g)),
      .EN_ADDR   (en_addr(g))
    ) u_group (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .src     (src_arr[g]),
      .wr_en   (reg_wr),
      .wr_addr (reg_addr),
      .wr_data (reg_wdata),
      .stat_o  (stat_arr[g]),
      .en_o    (en_arr[g]),
      .pend_o  (pend_vec[g])
    );
  end

  irqagg_master #(
    .WIDTH (WIDTH),
    .ADDR  (ADDR_MASTER)
  ) u_master (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .master_o (master_en)
  );

  // display bypasses the master gate; engine and power go through it
  always_comb begin
    cond_comb = pend_vec[IDX_DISP] |
                ((pend_vec[IDX_ENG] | pend_vec[IDX_PWR]) & master_en);
  end

  irqagg_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .cond_i   (cond_comb),
    .cond_q_o (cond_q),
    .irq_o    (cpu_irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == stat_addr(g)) reg_rdata = stat_arr[g];
      if (reg_addr == en_addr(g))   reg_rdata = en_arr[g];
    end
    if (reg_addr == ADDR_MASTER) reg_rdata = {master_en, {(WIDTH-1){1'b0}}};
  end

  assign disp_stat = stat_arr[IDX_DISP];
  assign disp_en   = en_arr[IDX_DISP];

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic [WIDTH-1:0] disp_src,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] disp_stat,
  input logic [WIDTH-1:0] disp_en,
  input logic             cond_q,
  input logic             cpu_irq
);

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (|disp_src) |=> ((disp_stat & $past(disp_src)) == $past(disp_src))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (reg_wr && reg_addr == 3'd0 && disp_src == '0) |=> ((disp_stat & $past(reg_wdata)) == '0)); // R3

  AST_DISP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (|(disp_stat & disp_en)) |=> cond_q); // R6

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cpu_irq |=> !cpu_irq); // R7

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cpu_irq |-> ($past(cond_q) && !$past(cond_q, 2))); // R8

endmodule

bind irq_edge_combiner irqagg_checker #(.WIDTH(WIDTH)) u_irqagg_checker (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .disp_src   (disp_src),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .disp_stat  (disp_stat),
  .disp_en    (disp_en),
  .cond_q     (cond_q),
  .cpu_irq    (cpu_irq)
);

// File: tb/irq_edge_combiner_bench.sv
module irq_edge_combiner_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] disp_src = '0, eng_src = '0, pwr_src = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         cpu_irq;

  int checks = 0, errors = 0, cyc = 0, dut_pulses = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_edge_combiner #(.WIDTH(W)) u_irq_edge_combiner (
    .clk(clk), .rst_n(rst_n), .disp_src(disp_src), .eng_src(eng_src),
    .pwr_src(pwr_src), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  // requirement-level model: predicts the cycle of every pulse
  logic [W-1:0] m_st[3], m_en[3];
  logic m_ms, m_cq, m_cqq, m_p;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin m_st[g] = '0; m_en[g] = '0; end
      m_ms = 0; m_cq = 0; m_cqq = 0;
    end else begin
      m_p   = m_cq & ~m_cqq;
      m_cqq = m_cq;
      m_cq  = (|(m_st[0] & m_en[0])) |
              (((|(m_st[1] & m_en[1])) | (|(m_st[2] & m_en[2]))) & m_ms);
      for (int g = 0; g < 3; g++) begin
        if (reg_wr && reg_addr == 3'(2*g))   m_st[g] = m_st[g] & ~reg_wdata;
        if (reg_wr && reg_addr == 3'(2*g+1)) m_en[g] = reg_wdata;
      end
      if (reg_wr && reg_addr == 3'd6) m_ms = reg_wdata[31];
      m_st[0] = m_st[0] | disp_src;
      m_st[1] = m_st[1] | eng_src;
      m_st[2] = m_st[2] | pwr_src;
      if (m_p) exp_q.push_back(cyc);
    end
  end

  // scoreboard monitor (R7 R8)
  always @(negedge clk) begin
    if (cpu_irq) begin
      dut_pulses++;
      checks++;
      if (exp_q.size() == 0 || exp_q[0] != cyc) begin
        errors++;
        $display("FAIL R7 R8 unexpected pulse: got cycle %0d, expected %0d", cyc,
                 (exp_q.size() == 0) ? -1 : exp_q[0]);
      end else begin
        void'(exp_q.pop_front());
      end
    end else if (exp_q.size() != 0 && exp_q[0] <= cyc) begin
      checks++; errors++;
      $display("FAIL R7 missing pulse: got none at cycle %0d, expected cycle %0d", cyc, exp_q[0]);
      void'(exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input int g, input logic [W-1:0] v);
    @(negedge clk);
    case (g) 0: disp_src = v; 1: eng_src = v; default: pwr_src = v; endcase
    @(negedge clk); disp_src = '0; eng_src = '0; pwr_src = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_pulses(input int exp, input string tag);
    idle(5);
    checks++;
    if (dut_pulses != exp) begin
      errors++;
      $display("FAIL %s pulse count: got %0d expected %0d", tag, dut_pulses, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(5);
    // R1: reset state
    for (int a = 0; a < 8; a++) chk_rd(3'(a), '0, "R1");
    checks++;
    if (cpu_irq !== 1'b0) begin errors++; $display("FAIL R1 irq after reset: got %b expected 0", cpu_irq); end

    // R5: enabled display source fires
    wr(3'd1, 32'h1);
    pulse(0, 32'h1);
    chk_pulses(1, "R5");
    // R2 R4: sticky, unmasked read
    pulse(0, 32'h20);
    chk_rd(3'd0, 32'h21, "R2 R4");
    // R8: held condition, no new pulse
    idle(10);
    chk_pulses(1, "R8");
    // R3: write-one-to-clear
    wr(3'd0, 32'h20);
    chk_rd(3'd0, 32'h1, "R3");
    wr(3'd0, 32'h1);
    chk_rd(3'd0, 32'h0, "R3");

    // R5: engine gated by master
    wr(3'd3, 32'hFF);
    pulse(1, 32'h4);
    chk_pulses(1, "R5");
    wr(3'd6, 32'hFFFF_FFFF);
    chk_pulses(2, "R5");
    chk_rd(3'd6, 32'h8000_0000, "R4");

    // R9: drop both enables, restore display first
    pulse(0, 32'h1);
    chk_pulses(2, "R8");
    wr(3'd6, 32'h0);
    wr(3'd1, 32'h0);
    idle(4);
    wr(3'd1, 32'h1);
    chk_pulses(3, "R9");
    // R9: drop both, restore master first
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h0);
    idle(4);
    wr(3'd6, 32'h8000_0000);
    chk_pulses(4, "R9");

    // R6: display fires with master off
    wr(3'd6, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h2);
    pulse(0, 32'h2);
    chk_pulses(5, "R6");
    chk_rd(3'd6, 32'h0, "R6 R4");

    // R2: set and clear in the same cycle
    pulse(2, 32'h8);
    chk_rd(3'd4, 32'h8, "R2");
    @(negedge clk); reg_wr = 1; reg_addr = 3'd4; reg_wdata = 32'h8; pwr_src = 32'h8;
    @(negedge clk); reg_wr = 0; reg_wdata = '0; pwr_src = '0;
    chk_rd(3'd4, 32'h8, "R2");
    wr(3'd4, 32'h8);
    chk_rd(3'd4, 32'h0, "R3");

    // R5: power group through master
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd5, 32'h1);
    wr(3'd6, 32'h8000_0000);
    chk_pulses(5, "R5");
    pulse(2, 32'h1);
    chk_pulses(6, "R5");

    // R4: unmapped address and enable read-back
    wr(3'd7, 32'h1234);
    chk_rd(3'd7, 32'h0, "R4");
    chk_rd(3'd3, 32'hFF, "R4");
    chk_rd(3'd5, 32'h1, "R4");

    idle(6);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending expected pulses: got %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule